// File: doc/BRIEF.md
# Receive Descriptor Ring Write-Back Engine

This block owns a ring of receive buffer descriptors stored in a small local memory. Each entry holds three fields. The first is a 16-bit status word. The second is a 16-bit length. The third is a 32-bit buffer address. Software arms an entry through a host write port by setting its empty flag, and it may also set the interrupt and wrap flags. The engine presents the current entry to a frame writer as a ready buffer, giving its address and index. When the writer reports that a buffer has been filled, the engine rewrites that entry. It stores the used length and the opening or closing marks, and it adds the frame status flags only when the entry closes a frame. It clears the empty flag, raises an interrupt request if the entry asked for one, and moves to the next entry.

Ring size is not held in a register. It comes from whichever entry carries the wrap flag: after that entry the engine returns to entry 0. If the current entry is not armed, the engine stalls rather than overwrite it. While stalled it reports busy, and it flags any completion the writer reports as dropped.

Status bits use big-endian numbering. Bit n of the list below is bit 15-n of the 16-bit word. Bit 0 is empty, bit 2 is wrap, bit 3 is interrupt, bit 4 is last and bit 5 is first. Bits 7 to 15 are frame flags, taken from `fill_flags[8:0]` in the same order.

Top module: `rxr_engine`

## Requirements
- R1: After reset, every entry reads as all zeros, `buf_idx` is 0, `busy` is 1, and `buf_ready`, `irq` and `drop` are 0.
- R2: `buf_ready` is 1, and `busy` is 0, exactly when the entry at `buf_idx` has its empty bit set (word bit 15). `buf_ptr` shows the address of that entry.
- R3: A `fill_done` that arrives while `buf_ready` is 0 changes no entry and does not move `buf_idx`. It makes `drop` high for one cycle after the edge.
- R4: An accepted completion with `fill_last`=1 writes `fill_len` into the length field. One with `fill_last`=0 writes BUF_BYTES there.
- R5: The first completion of a frame sets first (word bit 10), and later ones in the frame clear it. Last (word bit 11) equals `fill_last`.
- R6: Frame flag bits (word bits 8..0) are replaced by `fill_flags` only when `fill_last`=1. Otherwise they keep their previous contents.
- R7: Write-back clears empty (word bit 15). It keeps wrap (bit 13), interrupt (bit 12) and the buffer address unchanged.
- R8: After an accepted completion, `buf_idx` goes to 0 if the entry had wrap set (word bit 13) or was entry DEPTH-1. Otherwise it goes up by one.
- R9: `irq` is high for exactly the one cycle after the write-back of a closing entry whose interrupt bit (word bit 12) is set. It stays low for non-closing entries and for entries without that bit.
- R10: A host write in the same cycle as a write-back lands normally if it targets a different entry. If it targets the same entry, it is discarded and the write-back is kept.
- R11: A host write stores the given status and address and sets the length to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_idx | input | IDX_W | Entry written by host |
| host_status | input | 16 | Status word to store |
| host_ptr | input | 32 | Buffer address to store |
| host_rd_idx | input | IDX_W | Entry to read back |
| host_rd_status | output | 16 | Status of the read entry |
| host_rd_len | output | 16 | Length of the read entry |
| host_rd_ptr | output | 32 | Address of the read entry |
| buf_ready | output | 1 | Current entry is armed |
| buf_ptr | output | 32 | Address of the current entry |
| buf_idx | output | IDX_W | Index of the current entry |
| fill_done | input | 1 | Writer finished a buffer |
| fill_len | input | 16 | Bytes stored, used on closing entries |
| fill_last | input | 1 | This buffer closes the frame |
| fill_flags | input | 9 | Frame status flags, word bits 8..0 |
| busy | output | 1 | Engine stalled on an unarmed entry |
| drop | output | 1 | A completion was refused last cycle |
| irq | output | 1 | Interrupt request pulse |

## Verification
A host write and an engine write-back can fall in the same cycle. The bench provokes this twice by raising `host_wr` and `fill_done` together. In the first case the host re-arms entry 0 while entry 3, the end of the ring, closes a frame. The bench expects both writes to take effect, and `buf_ready` to be high immediately with the new address. In the second case the host targets the entry being written back. The bench expects the read-back to show the engine's status and length, and the old address, with the host write lost.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int ST_W    = 16;
   localparam int LEN_W   = 16;
   localparam int PTR_W   = 32;
   localparam int FLAGS_W = 9;

   // big-endian bit n maps to word bit 15-n
   localparam int B_EMPTY = 15;
   localparam int B_WRAP  = 13;
   localparam int B_INTR  = 12;
   localparam int B_LAST  = 11;
   localparam int B_FIRST = 10;

   typedef struct packed {
      logic [ST_W-1:0]  st;
      logic [LEN_W-1:0] len;
      logic [PTR_W-1:0] ptr;
   } rxr_desc_t;
endpackage

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem
   import rxr_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eng_we,
   input  logic [IDX_W-1:0]  eng_idx,
   input  logic [ST_W-1:0]   eng_st,
   input  logic [LEN_W-1:0]  eng_len,
   input  logic              host_we,
   input  logic [IDX_W-1:0]  host_idx,
   input  logic [ST_W-1:0]   host_st,
   input  logic [PTR_W-1:0]  host_ptr,
   input  logic [IDX_W-1:0]  rd_a_idx,
   output rxr_desc_t         rd_a,
   input  logic [IDX_W-1:0]  rd_b_idx,
   output rxr_desc_t         rd_b
);
   rxr_desc_t ents [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ents[g] <= '0;
         end else if (eng_we && eng_idx == IDX_W'(g)) begin
            // engine write-back wins over the host on the same entry
            ents[g].st  <= eng_st;
            ents[g].len <= eng_len;
         end else if (host_we && host_idx == IDX_W'(g)) begin
            ents[g].st  <= host_st;
            ents[g].len <= '0;
            ents[g].ptr <= host_ptr;
         end
      end
   end

   assign rd_a = ents[rd_a_idx];
   assign rd_b = ents[rd_b_idx];
endmodule

// File: rtl/rxr_wb_fmt.sv
module rxr_wb_fmt
   import rxr_pkg::*;
#(
   parameter int BUF_BYTES = 1536
) (
   input  logic [ST_W-1:0]    old_st,
   input  logic               in_frame,
   input  logic               last,
   input  logic [FLAGS_W-1:0] flags,
   input  logic [LEN_W-1:0]   used_len,
   output logic [ST_W-1:0]    new_st,
   output logic [LEN_W-1:0]   new_len
);
   always_comb begin
      new_st          = old_st;
      new_st[B_EMPTY] = 1'b0;
      new_st[B_LAST]  = last;
      new_st[B_FIRST] = !in_frame;
      if (last) begin
         new_st[FLAGS_W-1:0] = flags;
      end
      new_len = last ? used_len : LEN_W'(BUF_BYTES);
   end
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
   parameter int DEPTH       = 8,
   parameter bit WRAP_AT_END = 1'b1,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             wrap_bit,
   input  logic             last,
   output logic [IDX_W-1:0] cur_idx,
   output logic             in_frame
);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DEPTH - 1);
   logic at_end;

   if (WRAP_AT_END) begin : g_end_wrap
      assign at_end = (cur_idx == TOP_IDX);
   end else begin : g_no_end_wrap
      assign at_end = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_idx  <= '0;
         in_frame <= 1'b0;
      end else if (step) begin
         cur_idx  <= (wrap_bit || at_end) ? '0 : cur_idx + 1'b1;
         in_frame <= !last;
      end
   end
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
   import rxr_pkg::*;
#(
   parameter int DEPTH       = 8,
   parameter int BUF_BYTES   = 1536,
   parameter bit WRAP_AT_END = 1'b1,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr,
   input  logic [IDX_W-1:0]   host_idx,
   input  logic [15:0]        host_status,
   input  logic [31:0]        host_ptr,
   input  logic [IDX_W-1:0]   host_rd_idx,
   output logic [15:0]        host_rd_status,
   output logic [15:0]        host_rd_len,
   output logic [31:0]        host_rd_ptr,
   output logic               buf_ready,
   output logic [31:0]        buf_ptr,
   output logic [IDX_W-1:0]   buf_idx,
   input  logic               fill_done,
   input  logic [15:0]        fill_len,
   input  logic               fill_last,
   input  logic [8:0]         fill_flags,
   output logic               busy,
   output logic               drop,
   output logic               irq
);
   initial begin
      assert (DEPTH >= 2 && DEPTH <= 256)
         else $error("rxr_engine: DEPTH out of range");
      assert (BUF_BYTES > 0 && BUF_BYTES < (1 << LEN_W))
         else $error("rxr_engine: BUF_BYTES out of range");
   end

   rxr_desc_t        cur_d, rd_d;
   logic [ST_W-1:0]  cur_st, wb_st;
   logic [LEN_W-1:0] wb_len;
   logic [IDX_W-1:0] cur_idx;
   logic             in_frame, accept;

   rxr_desc_mem #(.DEPTH(DEPTH)) u_mem (
      .clk      (clk),
      .rst_n    (rst_n),
      .eng_we   (accept),
      .eng_idx  (cur_idx),
      .eng_st   (wb_st),
      .eng_len  (wb_len),
      .host_we  (host_wr),
      .host_idx (host_idx),
      .host_st  (host_status),
      .host_ptr (host_ptr),
      .rd_a_idx (cur_idx),
      .rd_a     (cur_d),
      .rd_b_idx (host_rd_idx),
      .rd_b     (rd_d)
   );

   assign cur_st = cur_d.st;
   assign accept = fill_done && cur_st[B_EMPTY];

   rxr_wb_fmt #(.BUF_BYTES(BUF_BYTES)) u_fmt (
      .old_st   (cur_st),
      .in_frame (in_frame),
      .last     (fill_last),
      .flags    (fill_flags),
      .used_len (fill_len),
      .new_st   (wb_st),
      .new_len  (wb_len)
   );

   rxr_ring_ptr #(.DEPTH(DEPTH), .WRAP_AT_END(WRAP_AT_END)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (accept),
      .wrap_bit (cur_st[B_WRAP]),
      .last     (fill_last),
      .cur_idx  (cur_idx),
      .in_frame (in_frame)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq  <= 1'b0;
         drop <= 1'b0;
      end else begin
         irq  <= accept && fill_last && cur_st[B_INTR];
         drop <= fill_done && !cur_st[B_EMPTY];
      end
   end

   assign buf_ready      = cur_st[B_EMPTY];
   assign busy           = !cur_st[B_EMPTY];
   assign buf_ptr        = cur_d.ptr;
   assign buf_idx        = cur_idx;
   assign host_rd_status = rd_d.st;
   assign host_rd_len    = rd_d.len;
   assign host_rd_ptr    = rd_d.ptr;
endmodule

// File: rtl/rxr_engine_chk.sv
module rxr_engine_chk #(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fill_done,
   input logic             fill_last,
   input logic             buf_ready,
   input logic [IDX_W-1:0] buf_idx,
   input logic [15:0]      cur_st,
   input logic             drop,
   input logic             irq
);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DEPTH - 1);

   p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(fill_done && fill_last && buf_ready && cur_st[12]));

   p_drop_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      drop |-> $past(fill_done && !buf_ready));

   p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_done && !buf_ready) |=> $stable(buf_idx));

   p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_done && buf_ready && cur_st[13]) |=> buf_idx == '0);

   p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_done && buf_ready && !cur_st[13] && buf_idx != TOP_IDX)
      |=> buf_idx == IDX_W'($past(buf_idx) + 1'b1));

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_done |=> $stable(buf_idx));
endmodule

bind rxr_engine rxr_engine_chk #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fill_done (fill_done),
   .fill_last (fill_last),
   .buf_ready (buf_ready),
   .buf_idx   (buf_idx),
   .cur_st    (cur_st),
   .drop      (drop),
   .irq       (irq)
);

// File: tb/tb_rxr_engine.sv
module tb_rxr_engine;
   localparam int DEPTH = 8;
   localparam int BUFB  = 1536;
   localparam int IW    = $clog2(DEPTH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_wr = 1'b0;
   logic [IW-1:0] host_idx = '0, host_rd_idx = '0, buf_idx;
   logic [15:0] host_status = '0, fill_len = '0, host_rd_status, host_rd_len;
   logic [31:0] host_ptr = '0, host_rd_ptr, buf_ptr;
   logic fill_done = 1'b0, fill_last = 1'b0;
   logic [8:0] fill_flags = '0;
   logic buf_ready, busy, drop, irq;
   int checks = 0, fails = 0, cyc = 0;

   always #5 clk = ~clk;

   rxr_engine #(.DEPTH(DEPTH), .BUF_BYTES(BUFB)) dut (.*);

   // vector table: one completion per row on a ring of entries 0..3
   localparam int          N = 4;
   localparam logic [15:0] V_LEN  [N] = '{16'd100, 16'd77, 16'd64, 16'd10};
   localparam logic        V_LAST [N] = '{1'b0, 1'b1, 1'b1, 1'b0};
   localparam logic [8:0]  V_FLG  [N] = '{9'h1FF, 9'h081, 9'h100, 9'h0FF};
   localparam logic [15:0] E_ST   [N] = '{16'h0400, 16'h1881, 16'h1D00, 16'h3400};
   localparam logic [15:0] E_LEN  [N] = '{16'd1536, 16'd77, 16'd64, 16'd1536};
   localparam logic        E_IRQ  [N] = '{1'b0, 1'b1, 1'b1, 1'b0};
   localparam logic [IW-1:0] E_NXT [N] = '{3'd1, 3'd2, 3'd3, 3'd0};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hwrite(input int idx, input logic [15:0] st, input logic [31:0] p);
      @(negedge clk);
      host_wr = 1'b1; host_idx = IW'(idx); host_status = st; host_ptr = p;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic fill(input logic [15:0] l, input logic lst, input logic [8:0] f);
      @(negedge clk);
      fill_done = 1'b1; fill_len = l; fill_last = lst; fill_flags = f;
      @(negedge clk);
      fill_done = 1'b0;
   endtask

   task automatic rd(input int idx);
      host_rd_idx = IW'(idx);
      #1;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 5000) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", busy, 1);
      chk("R1 ready", buf_ready, 0);
      chk("R1 irq", irq, 0);
      chk("R1 drop", drop, 0);
      chk("R1 idx", buf_idx, 0);
      rd(5);
      chk("R1 entry", {host_rd_status, host_rd_len}, 0);
      rst_n = 1'b1;

      hwrite(0, 16'h8000, 32'h1000);
      hwrite(1, 16'h9000, 32'h2000);
      hwrite(2, 16'h9000, 32'h3000);
      hwrite(3, 16'hB000, 32'h4000);
      rd(3);
      chk("R11 host len", host_rd_len, 0);
      chk("R11 host st", host_rd_status, 16'hB000);
      chk("R2 ready", buf_ready, 1);
      chk("R2 ptr", buf_ptr, 32'h1000);

      for (int i = 0; i < N; i++) begin
         fill(V_LEN[i], V_LAST[i], V_FLG[i]);
         rd(i);
         chk("R5 R6 R7 status", host_rd_status, E_ST[i]);
         chk("R4 len", host_rd_len, E_LEN[i]);
         chk("R7 ptr kept", host_rd_ptr, 32'h1000 * (i + 1));
         chk("R9 irq", irq, E_IRQ[i]);
         chk("R8 next", buf_idx, E_NXT[i]);
         @(negedge clk);
         chk("R9 one cycle", irq, 0);
      end

      // R3 stall: entry 0 consumed, not re-armed
      chk("R2 busy", busy, 1);
      fill(16'd9, 1'b1, 9'h1FF);
      chk("R3 drop", drop, 1);
      chk("R3 idx", buf_idx, 0);
      rd(0);
      chk("R3 untouched", host_rd_status, 16'h0400);
      @(negedge clk);
      chk("R3 drop pulse", drop, 0);

      // frame continues from entry 3: closing entry without first
      hwrite(0, 16'h8004, 32'h5000);
      fill(16'd5, 1'b1, 9'h010);
      rd(0);
      chk("R5 R6 close", host_rd_status, 16'h0810);
      chk("R9 no intr bit", irq, 0);

      // R6 flags kept on a non-final entry
      hwrite(1, 16'h8022, 32'h6000);
      fill(16'd5, 1'b0, 9'h1C0);
      rd(1);
      chk("R6 kept", host_rd_status, 16'h0422);
      chk("R4 full", host_rd_len, BUFB);

      hwrite(2, 16'h8000, 32'h7000);
      fill(16'd33, 1'b1, 9'h003);
      rd(2);
      chk("R5 R6 close2", host_rd_status, 16'h0803);
      chk("R9 intr clear", irq, 0);
      chk("R8 step", buf_idx, 3);

      // R10 host writes entry 0 while entry 3 closes a frame
      hwrite(3, 16'hA000, 32'h8000);
      @(negedge clk);
      fill_done = 1'b1; fill_len = 16'd12; fill_last = 1'b1; fill_flags = 9'h004;
      host_wr = 1'b1; host_idx = 0; host_status = 16'h8000; host_ptr = 32'h5555;
      @(negedge clk);
      fill_done = 1'b0; host_wr = 1'b0;
      rd(3);
      chk("R10 wb kept", host_rd_status, 16'h2C04);
      chk("R10 wb len", host_rd_len, 12);
      chk("R10 R8 wrap", buf_idx, 0);
      chk("R10 armed", buf_ready, 1);
      chk("R10 new ptr", buf_ptr, 32'h5555);

      // R10 same entry: engine wins
      @(negedge clk);
      fill_done = 1'b1; fill_len = 16'd1; fill_last = 1'b0; fill_flags = 9'h0;
      host_wr = 1'b1; host_idx = 0; host_status = 16'h8000; host_ptr = 32'h9999;
      @(negedge clk);
      fill_done = 1'b0; host_wr = 1'b0;
      rd(0);
      chk("R10 same st", host_rd_status, 16'h0400);
      chk("R10 same len", host_rd_len, BUFB);
      chk("R10 same ptr", host_rd_ptr, 32'h5555);
      chk("R8 after", buf_idx, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule